// File: doc/BRIEF.md
# Configurable Output Macrocell with Array Feedback

This block is one output cell placed behind a sum-of-products OR term in a programmable logic fabric. It takes the OR sum and either passes it straight to the pin or stores it in a D flip-flop. It can invert the value on the way out. It also picks the feedback signal that returns to the logic array. Two configuration bits set the behaviour. The upper bit chooses combinatorial operation (1) or registered operation (0). The lower bit chooses active-high output (1) or active-low output (0).

The flip-flop is controlled by two global terms. The preset term is synchronous and sets the stored bit high at the next rising clock edge. The clear term is asynchronous and forces the stored bit low at once. When both terms are true, clear wins. A product-term enable decides whether the pin is driven. An active-low reset input models power-on reset and clears the stored bit asynchronously.

All pins are plain level signals. The cell carries no data stream and has no handshake, so no back-pressure applies.

Top module: `macro_outcell`

## Requirements
- R1: While `rst_n` is low the stored bit is 0. With `cfg_sel` = 01 this gives `pad_out` = 0 and `fb_out` = 0. With `cfg_sel` = 00 it gives `pad_out` = 1.
- R2: In registered mode (`cfg_sel[1]` = 0), with preset and clear both false, the stored bit takes `sum_in` at each rising clock edge. The pin value does not change between edges.
- R3: When `preset_term` is true and `clear_term` is false at a rising edge, the stored bit becomes 1 after that edge, whatever `sum_in` is.
- R4: When `clear_term` goes true, the stored bit goes to 0 without waiting for a clock edge.
- R5: When `clear_term` and `preset_term` are both true, the stored bit is 0 after the edge.
- R6: When `cfg_sel[0]` = 0, the pin value is the inverse of the selected source. When `cfg_sel[0]` = 1, it is the selected source unchanged.
- R7: In combinatorial mode (`cfg_sel[1]` = 1), `pad_out` follows `sum_in` in the same cycle, with the polarity set by R6.
- R8: `fb_out` equals the stored bit when `cfg_sel[1]` = 0, and equals `pad_in` when `cfg_sel[1]` = 1.
- R9: `pad_oe` is 1 exactly when `oe_term` is 1. The pin is released while `oe_term` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low power-on reset, clears the stored bit asynchronously |
| cfg_sel | input | 2 | Configuration: bit 1 = combinatorial, bit 0 = active-high |
| sum_in | input | 1 | OR sum from the array |
| preset_term | input | 1 | Global synchronous preset term |
| clear_term | input | 1 | Global asynchronous clear term |
| oe_term | input | 1 | Output-enable product term |
| pad_in | input | 1 | Level currently seen on the pin |
| pad_out | output | 1 | Value driven to the pin |
| pad_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback returned to the array |

## Verification
All four configurations are driven with random sequences of sum, preset, clear, enable and pin values. A reference model predicts the stored bit, and the outputs are checked both just before and just after each clock edge. This separates registered timing from combinatorial timing and shows whether each polarity is applied. Keeping `pad_in` unrelated to `sum_in` reveals which source the feedback comes from. Directed cases raise clear in the middle of a cycle, assert preset and clear together, and check reset under both registered polarities.

// File: rtl/macro_outcell_pkg.sv
package macro_outcell_pkg;
  localparam int CFG_W    = 2;
  localparam int MODE_BIT = 1;  // 1 = combinatorial
  localparam int POL_BIT  = 0;  // 1 = active-high

  typedef enum logic [CFG_W-1:0] {
    CFG_REG_LOW   = 2'b00,
    CFG_REG_HIGH  = 2'b01,
    CFG_COMB_LOW  = 2'b10,
    CFG_COMB_HIGH = 2'b11
  } cell_cfg_e;
endpackage

// File: rtl/cellq_flop.sv
module cellq_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  input  logic preset_i,
  input  logic clear_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n or posedge clear_i) begin
    if (!rst_n)        q_o <= 1'b0;
    else if (clear_i)  q_o <= 1'b0;
    else if (preset_i) q_o <= 1'b1;
    else               q_o <= d_in;
  end

  // R2
  capture_sum_chk: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
    (!preset_i && !clear_i) |=> (q_o == $past(d_in)));

  // R3
  preset_sets_q_chk: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
    (preset_i && !clear_i) |=> q_o);

  // R4
  clear_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> !q_o);

  // R5
  clear_beats_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && preset_i) |=> !q_o);
endmodule

// File: rtl/cell_drive_sel.sv
module cell_drive_sel
  import macro_outcell_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             sum_i,
  input  logic             q_i,
  output logic             drive_o
);
  logic src;

  always_comb begin
    src     = cfg_i[MODE_BIT] ? sum_i : q_i;
    drive_o = cfg_i[POL_BIT] ? src : ~src;
  end
endmodule

// File: rtl/cell_fb_sel.sv
module cell_fb_sel
  import macro_outcell_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             q_i,
  input  logic             pin_i,
  output logic             fb_o
);
  always_comb fb_o = cfg_i[MODE_BIT] ? pin_i : q_i;
endmodule

// File: rtl/macro_outcell.sv
module macro_outcell
  import macro_outcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_sel,
  input  logic             sum_in,
  input  logic             preset_term,
  input  logic             clear_term,
  input  logic             oe_term,
  input  logic             pad_in,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             fb_out
);
  logic q_state;

  cellq_flop u_flop (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_in     (sum_in),
    .preset_i (preset_term),
    .clear_i  (clear_term),
    .q_o      (q_state)
  );

  cell_drive_sel u_drive (
    .cfg_i   (cfg_sel),
    .sum_i   (sum_in),
    .q_i     (q_state),
    .drive_o (pad_out)
  );

  cell_fb_sel u_fb (
    .cfg_i (cfg_sel),
    .q_i   (q_state),
    .pin_i (pad_in),
    .fb_o  (fb_out)
  );

  assign pad_oe = oe_term;

  // R8
  reg_fb_matches_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sel[MODE_BIT] |-> (fb_out == (cfg_sel[POL_BIT] ? pad_out : !pad_out)));

  // R7
  comb_high_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == CFG_COMB_HIGH) |-> (pad_out == sum_in));

  // R6
  comb_low_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == CFG_COMB_LOW) |-> (pad_out != sum_in));
endmodule

// File: tb/tb_macro_outcell.sv
module tb_macro_outcell;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg;
  logic       sum, pre, clr, oe, pin;
  logic       pad_out, pad_oe, fb_out;
  logic       mq;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  macro_outcell dut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg), .sum_in(sum),
    .preset_term(pre), .clear_term(clr), .oe_term(oe), .pad_in(pin),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
  );

  function automatic logic exp_pad(logic [1:0] c, logic s, logic q);
    logic src;
    src = c[1] ? s : q;
    return c[0] ? src : ~src;
  endfunction

  function automatic logic exp_fb(logic [1:0] c, logic p, logic q);
    return c[1] ? p : q;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, cfg[1] ? " R7/R6 pad" : " R2/R6 pad"}, pad_out, exp_pad(cfg, sum, mq));
    chk({ctx, " R8 fb"}, fb_out, exp_fb(cfg, pin, mq));
    chk({ctx, " R9 oe"}, pad_oe, oe);
  endtask

  // Drives one cycle's inputs at the falling edge, checks just after the
  // change (before the rising edge) and again just after the rising edge.
  task automatic step(input logic [1:0] c, input logic s, input logic p,
                      input logic k, input logic o, input logic pi,
                      input string ctx);
    cfg = c; sum = s; pre = p; clr = k; oe = o; pin = pi;
    #1;
    if (k) mq = 1'b0;
    check_all({ctx, " pre-edge"});
    @(posedge clk);
    if (k)      mq = 1'b0;
    else if (p) mq = 1'b1;
    else        mq = s;
    #1;
    check_all({ctx, " post-edge"});
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20250611;
    void'($urandom(seed));
    rst_n = 1'b0; cfg = 2'b01; sum = 1'b1; pre = 1'b0; clr = 1'b0;
    oe = 1'b1; pin = 1'b0; mq = 1'b0;
    #3;
    chk("R1 reset pad active-high", pad_out, 1'b0);
    chk("R1 reset fb", fb_out, 1'b0);
    cfg = 2'b00;
    #1;
    chk("R1 reset pad active-low", pad_out, 1'b1);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // R2 registered capture, both polarities
    step(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 cap1");
    step(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R2 cap0");
    step(2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6 reglow");
    // R3 preset overrides sum
    step(2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R3 preset");
    // R4 clear mid-cycle drops Q before the edge
    step(2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R4 clear");
    step(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 after clear");
    // R5 clear with preset
    step(2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R5 both");
    // R7 / R8 combinatorial with pin unrelated to sum
    step(2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7 combhigh");
    step(2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6 comblow");
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 oe off");

    for (int i = 0; i < 400; i++) begin
      step(2'($urandom_range(0, 3)), 1'($urandom), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 7) == 0), 1'($urandom), 1'($urandom), "rand");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule